// File: doc/BRIEF.md
# Timer with Write-Blocked Compare

This block is a 16-bit up-counter with two compare channels and an overflow flag, driven from a single system clock. The counter advances only on a timer tick, which is a clock enable from a small prescaler. The prescaler can stop the timer, run it on every system clock, or run it on every eighth system clock. Software writes the clock select, the counter and the two compare registers through a simple write port. It clears flags by writing ones to a clear register.

When software writes the counter, compare matches are masked until the next timer tick has passed, whether or not the timer is running. This lets a compare register be loaded with the same value as the counter without raising its flag when the timer starts. The cost is that a match on the value just written is lost. Overflow is flagged on the tick that wraps the counter from all ones to zero.

The flag vector uses fixed bit positions. Bit 0 is overflow, bit 1 is compare channel A and bit 2 is compare channel B. All flags are sticky until they are cleared.

Top module: `tmr_wblk`

## Requirements
- R1: After reset the counter reads 0, all flags read 0, and the clock select is 0, so the counter does not move until software changes the clock select.
- R2: With the clock select (address 0, bits [1:0]) at 0 or 3 there are no ticks, and the counter holds its value.
- R3: With the clock select at 1, the counter advances by one on every system clock.
- R4: With the clock select at 2, the counter advances once every 8 system clocks. The prescaler restarts whenever the clock select changes, so the first advance appears on the 9th clock edge after the edge that wrote the select.
- R5: On a tick with the counter at 16'hFFFF, the counter becomes 0 and flag bit 0 (overflow) becomes 1 at the same clock edge.
- R6: On a tick with the counter equal to compare register A (address 2) or B (address 3), flag bit 1 (A) or bit 2 (B) becomes 1 at that tick's clock edge, one clock after the matching value first appears on the counter.
- R7: A write to the counter (address 1) takes priority over a tick in the same cycle: the written value is loaded and is not incremented.
- R8: A counter write masks every compare match in its own cycle and on the next tick, so a match on the written value is not flagged while the timer runs.
- R9: The mask set by a counter write persists while the timer is stopped and is released only by the first tick after the timer restarts.
- R10: Flags are sticky. Writing 1 to a bit of the clear register (address 4) clears that flag, and leaves the other flags unchanged. A flag event and a clear of the same bit in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 counter, 2 compare A, 3 compare B, 4 flag clear |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| flags_o | output | 3 | Flags: bit 0 overflow, bit 1 compare A, bit 2 compare B |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two compare channels and a divide-by-8 prescaler. Small counter values near the compare registers, and loads just below 16'hFFFF, bring matches, the wrap and the write mask within a few clocks. The divide-by-8 setting is short enough that both the restart delay and the steady spacing of ticks can be measured edge by edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL     = 3'd0,
    REG_COUNT    = 3'd1,
    REG_CMP_A    = 3'd2,
    REG_CMP_B    = 3'd3,
    REG_FLAG_CLR = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    CS_STOP = 2'd0,
    CS_FAST = 2'd1,
    CS_SLOW = 2'd2,
    CS_RSVD = 2'd3
  } clk_sel_e;

  // Address of compare channel idx (A first, then B).
  function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
    return ADDR_W'(int'(REG_CMP_A) + idx);
  endfunction

  // Flag bit position of compare channel idx; bit 0 belongs to overflow.
  function automatic int cmp_flag_bit(input int idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PRESC_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [1:0]            sel_q;
  logic [PRESC_LOG2-1:0] pcnt;
  logic                  sel_changed;

  function automatic logic phase_done(input logic [PRESC_LOG2-1:0] v);
    return v == '1;
  endfunction

  assign sel_changed = (sel != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= CS_STOP;
      pcnt  <= '0;
    end else begin
      sel_q <= sel;
      if (sel_changed || sel != CS_SLOW) begin
        pcnt <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (sel)
      CS_FAST: tick = 1'b1;
      CS_SLOW: tick = !sel_changed && phase_done(pcnt);
      default: tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             block
);

  logic mask_q;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return v == '1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      mask_q <= 1'b0;
    end else if (load) begin
      count  <= load_val;
      mask_q <= 1'b1;
    end else if (tick) begin
      count  <= step(count);
      mask_q <= 1'b0;
    end
  end

  assign wrap_evt = tick && !load && at_top(count);
  assign block    = mask_q || load;

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] count,
  input  logic             tick,
  input  logic             block,
  output logic             match_evt
);

  logic [CNT_W-1:0] ref_q;

  function automatic logic equal(input logic [CNT_W-1:0] a,
                                 input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (wr) begin
      ref_q <= wr_val;
    end
  end

  assign match_evt = tick && !block && equal(count, ref_q);

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int FLAG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags
);

  function automatic logic [FLAG_W-1:0] next_flags(input logic [FLAG_W-1:0] cur,
                                                   input logic [FLAG_W-1:0] s,
                                                   input logic [FLAG_W-1:0] c);
    return (cur & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= next_flags(flags, set_vec, clr_vec);
    end
  end

endmodule

// File: rtl/tmr_wblk.sv
module tmr_wblk
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NUM_CMP    = 2,
  parameter int PRESC_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count_o,
  output logic [NUM_CMP:0]   flags_o
);

  localparam int FLAG_W = NUM_CMP + 1;

  logic [1:0]         clk_sel;
  logic               tick;
  logic               cnt_wr;
  logic               ctrl_wr;
  logic               clr_wr;
  logic               block;
  logic               wrap_evt;
  logic [NUM_CMP-1:0] match_evt;
  logic [FLAG_W-1:0]  set_vec;
  logic [FLAG_W-1:0]  clr_vec;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign cnt_wr  = wr_en && (wr_addr == REG_COUNT);
  assign clr_wr  = wr_en && (wr_addr == REG_FLAG_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel <= CS_STOP;
    end else if (ctrl_wr) begin
      clk_sel <= wr_data[1:0];
    end
  end

  tmr_prescale #(
    .PRESC_LOG2 (PRESC_LOG2)
  ) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (clk_sel),
    .tick  (tick)
  );

  tmr_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (wr_data),
    .count    (count_o),
    .wrap_evt (wrap_evt),
    .block    (block)
  );

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    logic ch_wr;
    assign ch_wr = wr_en && (wr_addr == cmp_addr(gi));

    tmr_compare #(
      .CNT_W (CNT_W)
    ) u_compare (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ch_wr),
      .wr_val    (wr_data),
      .count     (count_o),
      .tick      (tick),
      .block     (block),
      .match_evt (match_evt[gi])
    );

    assign set_vec[cmp_flag_bit(gi)] = match_evt[gi];
  end

  assign set_vec[0] = wrap_evt;
  assign clr_vec    = clr_wr ? wr_data[FLAG_W-1:0] : '0;

  tmr_flags #(
    .FLAG_W (FLAG_W)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags_o)
  );

endmodule

// File: rtl/tmr_wblk_chk.sv
module tmr_wblk_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         sel,
  input logic               tick,
  input logic               cnt_wr,
  input logic               block,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic [CNT_W-1:0]   count_o,
  input logic [NUM_CMP:0]   flags_o
);

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_STOP || sel == CS_RSVD) |-> !tick);  // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count_o));  // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count_o - $past(count_o)) == CNT_W'(1));  // R3

  AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_SLOW && tick) |=> !tick);  // R4

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (&count_o)) |=> flags_o[0]);  // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_o == $past(wr_data));  // R7

  AST_NO_MATCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> ((flags_o[NUM_CMP:1] & ~$past(flags_o[NUM_CMP:1])) == '0));  // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[0] |=> (flags_o[0] ||
                    $past(wr_en && wr_addr == REG_FLAG_CLR && wr_data[0])));  // R10

endmodule

bind tmr_wblk tmr_wblk_chk #(
  .CNT_W   (CNT_W),
  .NUM_CMP (NUM_CMP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (clk_sel),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .block   (block),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .count_o (count_o),
  .flags_o (flags_o)
);

// File: tb/tmr_wblk_bench.sv
`timescale 1ns/1ps
module tmr_wblk_bench;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CMPA = 3'd2;
  localparam logic [2:0] A_CMPB = 3'd3;
  localparam logic [2:0] A_CLR  = 3'd4;
  localparam logic [15:0] CMP_A_VAL = 16'h0010;
  localparam logic [15:0] CMP_B_VAL = 16'h0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic [2:0]  flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_wblk u_tmr_wblk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_o (count_o),
    .flags_o (flags_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count after reset", count_o, 0);
    check("R1 flags after reset", flags_o, 0);
    wait_neg(5);
    check("R1 stays stopped", count_o, 0);
  endtask

  task automatic t_stop;
    wr(A_CNT, 16'h1234);
    wait_neg(10);
    check("R2 held with select 0", count_o, 16'h1234);
    wr(A_CTRL, 16'd3);
    wait_neg(10);
    check("R2 held with select 3", count_o, 16'h1234);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_fast;
    logic [15:0] c;
    wr(A_CTRL, 16'd1);
    c = count_o;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R3 step per clock", count_o, 32'(c + 16'(k)));
    end
  endtask

  task automatic t_load;
    wr(A_CNT, 16'h0100);
    check("R7 load not incremented", count_o, 16'h0100);
    @(negedge clk);
    check("R7 counting resumes", count_o, 16'h0101);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_ovf;
    wr(A_CLR, 16'h0007);
    wr(A_CNT, 16'hFFFD);
    wr(A_CTRL, 16'd1);
    wait_neg(2);
    check("R5 at max", count_o, 16'hFFFF);
    check("R5 no overflow yet", flags_o[0], 0);
    @(negedge clk);
    check("R5 wrapped to zero", count_o, 16'h0000);
    check("R5 overflow set", flags_o[0], 1);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_cmp(input int ch);
    logic [15:0] tgt;
    tgt = (ch == 0) ? CMP_A_VAL : CMP_B_VAL;
    wr(A_CLR, 16'h0007);
    wr(A_CNT, tgt - 16'd2);
    wr(A_CTRL, 16'd1);
    wait_neg(2);
    check("R6 flag not before match tick", flags_o[ch+1], 0);
    @(negedge clk);
    check("R6 compare flag set", flags_o[ch+1], 1);
    check("R6 other channel idle", flags_o[2-ch], 0);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_block_run;
    wr(A_CLR, 16'h0007);
    wr(A_CNT, 16'h0005);
    wr(A_CTRL, 16'd1);
    wr(A_CNT, CMP_A_VAL);
    wait_neg(3);
    check("R8 count advanced past match", count_o, 32'(CMP_A_VAL + 16'd3));
    check("R8 match on written value lost", flags_o[1], 0);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_block_stop;
    wr(A_CLR, 16'h0007);
    wr(A_CNT, CMP_B_VAL);
    wait_neg(20);
    wr(A_CTRL, 16'd1);
    wait_neg(3);
    check("R9 count advanced after restart", count_o, 32'(CMP_B_VAL + 16'd3));
    check("R9 mask held while stopped", flags_o[2], 0);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_slow;
    wr(A_CNT, 16'h0200);
    wr(A_CTRL, 16'd2);
    wait_neg(8);
    check("R4 no advance before 9th edge", count_o, 16'h0200);
    @(negedge clk);
    check("R4 first advance on 9th edge", count_o, 16'h0201);
    wait_neg(7);
    check("R4 held within period", count_o, 16'h0201);
    @(negedge clk);
    check("R4 second advance 8 later", count_o, 16'h0202);
    wr(A_CTRL, 16'd0);
  endtask

  task automatic t_flags;
    wr(A_CLR, 16'h0007);
    wr(A_CNT, 16'hFFFE);
    wr(A_CTRL, 16'd1);
    wr(A_CLR, 16'h0001);
    check("R10 set wins over clear", flags_o[0], 1);
    wr(A_CTRL, 16'd0);
    wr(A_CNT, CMP_B_VAL - 16'd2);
    wr(A_CTRL, 16'd1);
    wait_neg(3);
    wr(A_CTRL, 16'd0);
    wait_neg(5);
    check("R10 flags sticky", flags_o, 3'b101);
    wr(A_CLR, 16'h0001);
    check("R10 clear only selected bit", flags_o, 3'b100);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(A_CMPA, CMP_A_VAL);
    wr(A_CMPB, CMP_B_VAL);
    t_stop();
    t_fast();
    t_load();
    t_ovf();
    t_cmp(0);
    t_cmp(1);
    t_block_run();
    t_block_stop();
    t_slow();
    t_flags();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule